// File: doc/BRIEF.md
# Debug Trigger Register Bank

This block holds the configuration for a small set of hardware breakpoint triggers. Software reaches the triggers through three control-register addresses. One is an index register that picks the current trigger. One is a packed control word for that trigger. One is the compare value for that trigger. A fourth address is reserved and always reads zero. The comparison of addresses against the compare values is done elsewhere. This block only stores, protects, packs and unpacks the settings.

A trigger can be claimed by the debugger through its debug-owned bit. While that bit is set, software outside debug mode cannot change the trigger. The block also produces three summary flags, one each for fetch, load and store. Each flag says whether any trigger watches that kind of access, so the rest of the core can skip the comparison when nothing is armed. Every accepted control-word write also raises a one-cycle pulse that tells the translation cache to flush.

Top module: `trig_bank`

## Requirements
- R1: After reset the index reads 0. Every trigger's control word reads as type 2 only (0x2000_0000 for XLEN 32) and every compare value reads 0. The three summary flags and the flush pulse are low.
- R2: A write to the index address (0x7A0) is taken only when the written value is below NUM_TRIG. Any other value leaves the index unchanged. The index reads back on the same address.
- R3: The control word at address 0x7A1 has the following layout:
  - bit 0: load enable
  - bit 1: store enable
  - bit 2: execute enable
  - bits 6:3: per-privilege enables
  - bits 10:7: match mode
  - bit 11: chain
  - bits 17:12: action
  - bit 18: timing
  - bit 19: select
  - bit XLEN-5: debug-owned
  - bits XLEN-1:XLEN-4: type, always read as 2
  
  Every other bit reads 0. A write stores the writable fields of the selected trigger, and a read returns them packed.
- R4: When a control-word write has bit 2 set, the stored timing bit reads 0 whatever was written to bit 18.
- R5: The compare value at address 0x7A2 is stored per trigger with the full XLEN width. It reads back for the selected trigger.
- R6: If the selected trigger's debug-owned bit is set and `dbg_mode` is low, writes to 0x7A1 and 0x7A2 are ignored. With `dbg_mode` high they are taken.
- R7: Address 0x7A3 and any address other than 0x7A0..0x7A3 read 0.
- R8: Each summary flag is the OR over all triggers of one enable: `chk_fetch` of bit 2, `chk_load` of bit 0 and `chk_store` of bit 1. A flag reflects a write from the clock edge that stores it.
- R9: `flush_pulse` is high for exactly the one cycle after an accepted control-word write. A blocked write does not raise it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | 12 | Register address |
| csr_we | input | 1 | Write enable for the current address |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data for the current address (combinational) |
| dbg_mode | input | 1 | High while the hart is in debug mode |
| chk_fetch | output | 1 | Some trigger watches instruction fetch |
| chk_load | output | 1 | Some trigger watches loads |
| chk_store | output | 1 | Some trigger watches stores |
| flush_pulse | output | 1 | One-cycle translation-cache flush request |

## Verification
Read data is combinational, so a read is due in the same cycle as its address. A write lands on the following rising edge. Its effect on read data and on the three summary flags is therefore due one edge after the write is presented. The flush pulse comes from a register fed by the accepted-write condition, so it is due in the cycle after that edge. The bench drives every vector just after a falling edge and compares read data and flags 1 ns later. It advances its reference model at the rising edge, and it expects the flush pulse on the vector that follows an accepted control-word write.

// File: rtl/trig_pkg.sv
package trig_pkg;

  localparam int P_LD    = 0;
  localparam int P_ST    = 1;
  localparam int P_EXE   = 2;
  localparam int P_PRIV  = 3;
  localparam int P_MATCH = 7;
  localparam int P_CHAIN = 11;
  localparam int P_ACT   = 12;
  localparam int P_TIM   = 18;
  localparam int P_SEL   = 19;
  localparam logic [3:0] TRIG_TYPE = 4'd2;

  typedef struct packed {
    logic       dbg_own;
    logic       sel_data;
    logic       timing;
    logic [5:0] action;
    logic       chain;
    logic [3:0] mode;
    logic [3:0] priv_en;
    logic       exe_en;
    logic       st_en;
    logic       ld_en;
  } trig_ctl_t;

  function automatic logic [63:0] pack_ctl(trig_ctl_t c, int xw);
    logic [63:0] w;
    w = '0;
    w[P_LD]                = c.ld_en;
    w[P_ST]                = c.st_en;
    w[P_EXE]               = c.exe_en;
    w[P_PRIV +: 4]         = c.priv_en;
    w[P_MATCH +: 4]        = c.mode;
    w[P_CHAIN]             = c.chain;
    w[P_ACT +: 6]          = c.action;
    w[P_TIM]               = c.timing;
    w[P_SEL]               = c.sel_data;
    w                      = w | (64'(c.dbg_own) << (xw - 5));
    w                      = w | (64'(TRIG_TYPE) << (xw - 4));
    return w;
  endfunction

  function automatic trig_ctl_t unpack_ctl(logic [63:0] w, int xw);
    trig_ctl_t c;
    logic [63:0] sh;
    sh         = w >> (xw - 5);
    c.dbg_own  = sh[0];
    c.sel_data = w[P_SEL];
    c.timing   = w[P_TIM];
    c.action   = w[P_ACT +: 6];
    c.chain    = w[P_CHAIN];
    c.mode     = w[P_MATCH +: 4];
    c.priv_en  = w[P_PRIV +: 4];
    c.exe_en   = w[P_EXE];
    c.st_en    = w[P_ST];
    c.ld_en    = w[P_LD];
    return c;
  endfunction

  function automatic trig_ctl_t settle_timing(trig_ctl_t c);
    trig_ctl_t r;
    r = c;
    if (c.exe_en) r.timing = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/trig_slot.sv
module trig_slot
  import trig_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_ctl,
  input  logic            wr_cmp,
  input  trig_ctl_t       ctl_in,
  input  logic [XLEN-1:0] cmp_in,
  output trig_ctl_t       ctl_q,
  output logic [XLEN-1:0] cmp_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      cmp_q <= '0;
    end else begin
      if (wr_ctl) ctl_q <= ctl_in;
      if (wr_cmp) cmp_q <= cmp_in;
    end
  end

endmodule

// File: rtl/trig_any.sv
module trig_any #(
  parameter int NUM_TRIG = 4
) (
  input  logic [NUM_TRIG-1:0] exe_vec,
  input  logic [NUM_TRIG-1:0] ld_vec,
  input  logic [NUM_TRIG-1:0] st_vec,
  output logic                any_exe,
  output logic                any_ld,
  output logic                any_st
);

  assign any_exe = |exe_vec;
  assign any_ld  = |ld_vec;
  assign any_st  = |st_vec;

endmodule

// File: rtl/trig_bank.sv
module trig_bank
  import trig_pkg::*;
#(
  parameter int          NUM_TRIG = 4,
  parameter int          XLEN     = 32,
  parameter logic [11:0] A_SEL    = 12'h7A0,
  parameter logic [11:0] A_CTL    = 12'h7A1,
  parameter logic [11:0] A_CMP    = 12'h7A2,
  parameter logic [11:0] A_AUX    = 12'h7A3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [11:0]     csr_addr,
  input  logic            csr_we,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  input  logic            dbg_mode,
  output logic            chk_fetch,
  output logic            chk_load,
  output logic            chk_store,
  output logic            flush_pulse
);

  localparam int SELW = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;

  logic [SELW-1:0]      tsel_q;
  trig_ctl_t            ctl_q [NUM_TRIG];
  logic [XLEN-1:0]      cmp_q [NUM_TRIG];
  logic [NUM_TRIG-1:0]  exe_vec, ld_vec, st_vec;

  // Named internal events
  logic            sel_in_range;
  trig_ctl_t       cur_ctl;
  logic [XLEN-1:0] cur_cmp;
  logic            wr_locked;
  logic            sel_wr_ok;
  logic            d1_wr_ok;
  logic            d1_wr_blocked;
  logic            d2_wr_ok;
  trig_ctl_t       new_ctl;
  logic [XLEN-1:0] d1_view;

  assign sel_in_range = (32'(tsel_q) < NUM_TRIG);
  assign cur_ctl      = sel_in_range ? ctl_q[tsel_q] : '0;
  assign cur_cmp      = sel_in_range ? cmp_q[tsel_q] : '0;
  assign wr_locked    = cur_ctl.dbg_own & ~dbg_mode;

  assign sel_wr_ok     = csr_we && (csr_addr == A_SEL) && (csr_wdata < XLEN'(NUM_TRIG));
  assign d1_wr_ok      = csr_we && (csr_addr == A_CTL) && sel_in_range && !wr_locked;
  assign d1_wr_blocked = csr_we && (csr_addr == A_CTL) && wr_locked;
  assign d2_wr_ok      = csr_we && (csr_addr == A_CMP) && sel_in_range && !wr_locked;

  assign new_ctl = settle_timing(unpack_ctl(64'(csr_wdata), XLEN));
  assign d1_view = sel_in_range ? XLEN'(pack_ctl(cur_ctl, XLEN)) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) tsel_q <= '0;
    else if (sel_wr_ok) tsel_q <= SELW'(csr_wdata);
  end

  for (genvar gi = 0; gi < NUM_TRIG; gi++) begin : g_slot
    logic hit;
    assign hit = (32'(tsel_q) == gi);
    trig_slot #(.XLEN(XLEN)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_ctl (d1_wr_ok && hit),
      .wr_cmp (d2_wr_ok && hit),
      .ctl_in (new_ctl),
      .cmp_in (csr_wdata),
      .ctl_q  (ctl_q[gi]),
      .cmp_q  (cmp_q[gi])
    );
    assign exe_vec[gi] = ctl_q[gi].exe_en;
    assign ld_vec[gi]  = ctl_q[gi].ld_en;
    assign st_vec[gi]  = ctl_q[gi].st_en;
  end

  trig_any #(.NUM_TRIG(NUM_TRIG)) u_any (
    .exe_vec (exe_vec),
    .ld_vec  (ld_vec),
    .st_vec  (st_vec),
    .any_exe (chk_fetch),
    .any_ld  (chk_load),
    .any_st  (chk_store)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) flush_pulse <= 1'b0;
    else        flush_pulse <= d1_wr_ok;
  end

  always_comb begin
    unique case (csr_addr)
      A_SEL:   csr_rdata = XLEN'(tsel_q);
      A_CTL:   csr_rdata = d1_view;
      A_CMP:   csr_rdata = cur_cmp;
      default: csr_rdata = '0;
    endcase
  end

endmodule

// File: rtl/trig_bank_chk.sv
module trig_bank_chk
  import trig_pkg::*;
#(
  parameter int          NUM_TRIG = 4,
  parameter int          XLEN     = 32,
  parameter int          SELW     = 2,
  parameter logic [11:0] A_SEL    = 12'h7A0,
  parameter logic [11:0] A_CTL    = 12'h7A1,
  parameter logic [11:0] A_AUX    = 12'h7A3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [11:0]     csr_addr,
  input logic            csr_we,
  input logic [XLEN-1:0] csr_wdata,
  input logic [XLEN-1:0] csr_rdata,
  input logic            chk_fetch,
  input logic            flush_pulse,
  input logic [SELW-1:0] tsel_q,
  input logic            d1_wr_ok,
  input logic            d1_wr_blocked,
  input logic [XLEN-1:0] d1_view
);

  // R2
  sel_oob_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_addr == A_SEL && csr_wdata >= XLEN'(NUM_TRIG)) |=> $stable(tsel_q));

  // R3
  type_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == A_CTL) |-> (csr_rdata[XLEN-1 -: 4] == TRIG_TYPE));

  // R4
  exe_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d1_wr_ok && csr_wdata[P_EXE]) |=> !d1_view[P_TIM]);

  // R6
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d1_wr_blocked |=> $stable(d1_view));

  // R7
  aux_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == A_AUX) |-> (csr_rdata == '0));

  // R8
  fetch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d1_wr_ok && csr_wdata[P_EXE]) |=> chk_fetch);

  // R9
  flush_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pulse |-> $past(d1_wr_ok));

  // R9
  flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d1_wr_blocked |=> !flush_pulse);

endmodule

bind trig_bank trig_bank_chk #(
  .NUM_TRIG (NUM_TRIG),
  .XLEN     (XLEN),
  .SELW     (SELW),
  .A_SEL    (A_SEL),
  .A_CTL    (A_CTL),
  .A_AUX    (A_AUX)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .csr_addr      (csr_addr),
  .csr_we        (csr_we),
  .csr_wdata     (csr_wdata),
  .csr_rdata     (csr_rdata),
  .chk_fetch     (chk_fetch),
  .flush_pulse   (flush_pulse),
  .tsel_q        (tsel_q),
  .d1_wr_ok      (d1_wr_ok),
  .d1_wr_blocked (d1_wr_blocked),
  .d1_view       (d1_view)
);

// File: tb/trig_bank_tb.sv
`timescale 1ns/1ps
module trig_bank_tb;

  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] csr_addr = '0;
  logic        csr_we = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        dbg_mode = 1'b0;
  logic        chk_fetch, chk_load, chk_store, flush_pulse;

  always #2.5 clk = ~clk;

  trig_bank u_dut (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .dbg_mode(dbg_mode),
    .chk_fetch(chk_fetch), .chk_load(chk_load), .chk_store(chk_store),
    .flush_pulse(flush_pulse)
  );

  int vectors = 0;
  int fails = 0;

  // Reference model state
  int unsigned m_sel;
  logic [31:0] m_ctl [N];
  logic [31:0] m_cmp [N];
  logic        m_flush;

  function automatic logic [31:0] model_read(logic [11:0] a);
    case (a)
      12'h7A0: return m_sel;
      12'h7A1: return 32'h2000_0000 | m_ctl[m_sel];
      12'h7A2: return m_cmp[m_sel];
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic any_bit(int b);
    logic r = 1'b0;
    for (int k = 0; k < N; k++) r = r | m_ctl[k][b];
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (addr %h)", tag, act, exp, csr_addr);
    end
  endtask

  task automatic cyc(string tag, logic [11:0] a, logic we, logic [31:0] d, logic dbg);
    logic locked;
    logic [31:0] v;
    csr_addr = a; csr_we = we; csr_wdata = d; dbg_mode = dbg;
    #1;
    check(tag, csr_rdata, model_read(a));
    check("R8 fetch", 32'(chk_fetch), 32'(any_bit(2)));
    check("R8 load",  32'(chk_load),  32'(any_bit(0)));
    check("R8 store", 32'(chk_store), 32'(any_bit(1)));
    check("R9 flush", 32'(flush_pulse), 32'(m_flush));
    @(posedge clk);
    locked = m_ctl[m_sel][27] && !dbg;
    m_flush = 1'b0;
    if (we) begin
      if (a == 12'h7A0 && d < N) m_sel = d;
      if (a == 12'h7A1 && !locked) begin
        v = d & 32'h080F_FFFF;
        if (v[2]) v[18] = 1'b0;
        m_ctl[m_sel] = v;
        m_flush = 1'b1;
      end
      if (a == 12'h7A2 && !locked) m_cmp[m_sel] = d;
    end
    @(negedge clk);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    m_sel = 0; m_flush = 1'b0;
    for (int k = 0; k < N; k++) begin m_ctl[k] = '0; m_cmp[k] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state on every address
    cyc("R1 sel",  12'h7A0, 0, 0, 0);
    cyc("R1 ctl",  12'h7A1, 0, 0, 0);
    cyc("R1 cmp",  12'h7A2, 0, 0, 0);
    // R4: execute with timing written as 1
    cyc("R4 wr",   12'h7A1, 1, 32'hFFFF_FFFF, 0);
    cyc("R4 rd",   12'h7A1, 0, 0, 0);
    cyc("R3 wr",   12'h7A1, 1, 32'h0004_5A3B & ~32'h4, 0);
    cyc("R3 rd",   12'h7A1, 0, 0, 0);
    // R2: out-of-range selects are dropped
    cyc("R2 oob",  12'h7A0, 1, 4, 0);
    cyc("R2 rd",   12'h7A0, 0, 0, 0);
    cyc("R2 big",  12'h7A0, 1, 32'hFFFF_FFFF, 0);
    cyc("R2 top",  12'h7A0, 1, 3, 0);
    cyc("R2 rd3",  12'h7A0, 0, 0, 0);
    cyc("R3 st",   12'h7A1, 1, 32'h2, 0);
    cyc("R5 wr",   12'h7A2, 1, 32'hCAFE_0123, 0);
    cyc("R5 rd",   12'h7A2, 0, 0, 0);
    // R6: debug-owned trigger on index 2
    cyc("R2 s2",   12'h7A0, 1, 2, 0);
    cyc("R6 own",  12'h7A1, 1, 32'h0800_0001, 1);
    cyc("R6 blk",  12'h7A1, 1, 32'h0000_0004, 0);
    cyc("R6 rd",   12'h7A1, 0, 0, 0);
    cyc("R6 blk2", 12'h7A2, 1, 32'h1234_5678, 0);
    cyc("R6 rd2",  12'h7A2, 0, 0, 0);
    cyc("R6 dbg",  12'h7A2, 1, 32'h8765_4321, 1);
    cyc("R6 free", 12'h7A1, 1, 32'h0000_0000, 1);
    cyc("R6 rd3",  12'h7A1, 0, 0, 0);
    // R7: reserved and unknown addresses
    cyc("R7 aux",  12'h7A3, 0, 0, 0);
    cyc("R7 unk",  12'h300, 1, 32'hFFFF_FFFF, 0);
    cyc("R7 unk2", 12'h7A4, 0, 0, 0);
    // Mixed traffic across all triggers
    lf = 32'h1ACE_B00C;
    for (int i = 0; i < 120; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      case (lf[5:4])
        2'd0: cyc("R2 mix", 12'h7A0, lf[6], {29'd0, lf[10:8]}, lf[7]);
        2'd1: cyc("R3 mix", 12'h7A1, lf[6], lf, lf[7]);
        2'd2: cyc("R5 mix", 12'h7A2, lf[6], ~lf, lf[7]);
        default: cyc("R7 mix", {8'h7A, lf[11:8]}, lf[6], lf, lf[7]);
      endcase
    end
    cyc("R9 end", 12'h7A1, 0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule